// File: doc/BRIEF.md
# Binary Clock Divider with Guarded Reset

This block divides a slow clock signal, sampled in the system clock domain, into a chain of binary divided outputs. With the default configuration it produces four outputs at one half, one quarter, one eighth and one sixteenth of the input rate. Each output is one bit of a small counter, so the outputs are periodic square waves.

A divider reset input has two selectable behaviours, chosen by a style input. In preset style, a rising reset edge loads every output high, and the counter then counts down. In hold style, all outputs stay low for as long as the reset input is high, and the counter counts up once reset is released.

Routing delays often make the first clock edge of a freshly restarted clock source arrive a few cycles after a shared reset. Such an edge would otherwise skip the first step. To stop this, a guard window follows each reset, and clock edges that arrive inside it are ignored. The window is a parameter counted in system clock cycles. The integrator sets it to about one millisecond of system clock.

Top module: `clkdiv_guarded`

## Requirements
- R1: After system reset (rst_n low), all divided outputs are 0, and rising clock edges seen in the first GUARD_CYC system cycles after rst_n goes high are ignored.
- R2: In preset style (style_i = 0), a rising edge on div_rst_i sets every divided output to 1 one system cycle later, whatever the level of clk_in at that time.
- R3: In preset style, the outputs hold all ones until the first accepted rising clock edge. On that edge only the divide-by-2 output goes low. The divide-by-4 output first goes low on the second accepted edge.
- R4: div_o[i] divides by 2^(i+1), so bit 0 is /2 and the top bit is /16 by default. In preset style, each accepted rising clock edge decrements div_o by one, and the count wraps from 0 to all ones.
- R5: In hold style (style_i = 1), div_o is 0 in every cycle after one in which div_rst_i was high, and clock edges have no effect during that time.
- R6: In hold style, with div_rst_i low, each accepted rising clock edge increments div_o by one, and the count wraps from all ones to 0.
- R7: In preset style, a rising clock edge seen 1 to GUARD_CYC system cycles after the reset rising edge is ignored; one seen GUARD_CYC+1 cycles after is accepted. In hold style, the window is counted from the last cycle in which div_rst_i was high.
- R8: When a reset rising edge and a clock rising edge are sampled in the same cycle, the reset action applies and the clock edge is dropped.
- R9: Only a low-to-high transition of clk_in advances the count. Holding clk_in high or low, or a falling edge, leaves div_o unchanged.
- R10: In preset style, the reset is edge-sensitive. Holding div_rst_i high after its rising edge does not freeze the counter, so clock edges after the guard window count down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| clk_in | input | 1 | Clock signal to be divided, sampled on clk |
| div_rst_i | input | 1 | Divider reset request, sampled on clk |
| style_i | input | 1 | Reset style: 0 selects preset with down-count, 1 selects hold-low with up-count |
| div_o | output | NUM_STAGES | Divided clocks, bit i at 1/2^(i+1) of the input rate |

## Verification
A corrupted counter bit shows on the matching divided output in the very next system cycle, because the outputs are the counter flops themselves. A sweep over a full wrap period in each direction exposes any stuck or mis-chained bit within sixteen accepted edges. A guard window that is one cycle too short or too long changes whether an edge placed exactly at the window boundary moves div_o. The boundary edges are therefore placed on both sides of it, and the outputs are read one cycle later. A wrong priority between reset and clock shows at once as all ones or zero, compared with the value one step along.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

   // Reset behaviour selected by the style input
   typedef enum logic {
      STYLE_PRESET = 1'b0,   // load all ones on reset edge, count down
      STYLE_HOLD   = 1'b1    // clear while reset is high, count up
   } rst_style_e;

   // Per-cycle control decoded from sampled inputs
   typedef struct packed {
      logic load_ones;
      logic clear;
      logic step;
      logic dir_up;
   } cnt_ctrl_t;

   // Width needed to hold the value n
   function automatic int unsigned width_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cd_edge_sense.sv
`timescale 1ns/1ps
module cd_edge_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i;
   end

   assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/cd_guard.sv
`timescale 1ns/1ps
module cd_guard #(
   parameter int unsigned GUARD_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   output logic open_o
);
   import clkdiv_pkg::*;

   localparam int unsigned GW = width_for(GUARD_CYC);
   localparam logic [GW-1:0] FULL = GW'(GUARD_CYC);
   localparam logic [GW-1:0] ONE  = GW'(1);

   logic [GW-1:0] remain_q;

   // Reloads on system reset and on every arming cycle, then drains to zero
   always_ff @(posedge clk) begin
      if (!rst_n)                remain_q <= FULL;
      else if (arm_i)            remain_q <= FULL;
      else if (remain_q != '0)   remain_q <= remain_q - ONE;
   end

   assign open_o = (remain_q == '0);

endmodule

// File: rtl/cd_count.sv
`timescale 1ns/1ps
module cd_count #(
   parameter int unsigned NUM_STAGES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  clkdiv_pkg::cnt_ctrl_t ctrl_i,
   output logic [NUM_STAGES-1:0] q_o
);

   // chain_up[i]: all bits below i are one; chain_dn[i]: all below i are zero
   logic [NUM_STAGES-1:0] chain_up;
   logic [NUM_STAGES-1:0] chain_dn;

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_bit
      logic bit_q;
      logic flip;

      if (i == 0) begin : g_first
         assign chain_up[i] = 1'b1;
         assign chain_dn[i] = 1'b1;
      end else begin : g_rest
         assign chain_up[i] = chain_up[i-1] &  q_o[i-1];
         assign chain_dn[i] = chain_dn[i-1] & ~q_o[i-1];
      end

      assign flip = ctrl_i.step & (ctrl_i.dir_up ? chain_up[i] : chain_dn[i]);

      always_ff @(posedge clk) begin
         if (!rst_n)                bit_q <= 1'b0;
         else if (ctrl_i.load_ones) bit_q <= 1'b1;
         else if (ctrl_i.clear)     bit_q <= 1'b0;
         else if (flip)             bit_q <= ~bit_q;
      end

      assign q_o[i] = bit_q;
   end

endmodule

// File: rtl/clkdiv_guarded.sv
`timescale 1ns/1ps
module clkdiv_guarded #(
   parameter int unsigned NUM_STAGES = 4,
   parameter int unsigned GUARD_CYC  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clk_in,
   input  logic                  div_rst_i,
   input  logic                  style_i,
   output logic [NUM_STAGES-1:0] div_o
);
   import clkdiv_pkg::*;

   // Elaboration-time parameter checks
   if (NUM_STAGES < 1 || NUM_STAGES > 32) begin : g_bad_stages
      $error("NUM_STAGES must lie in 1..32");
   end
   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("GUARD_CYC must be at least 1");
   end

   rst_style_e style;
   logic       tick_rise;
   logic       rst_rise;
   logic       hold_active;
   logic       guard_open;
   cnt_ctrl_t  ctrl;

   assign style = rst_style_e'(style_i);

   cd_edge_sense u_tick_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (clk_in),
      .rise_o (tick_rise)
   );

   cd_edge_sense u_rst_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (div_rst_i),
      .rise_o (rst_rise)
   );

   assign hold_active = (style == STYLE_HOLD) && div_rst_i;

   cd_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (rst_rise | hold_active),
      .open_o (guard_open)
   );

   always_comb begin
      ctrl.load_ones = rst_rise && (style == STYLE_PRESET);
      ctrl.clear     = hold_active;
      ctrl.step      = tick_rise && guard_open && !rst_rise && !hold_active;
      ctrl.dir_up    = (style == STYLE_HOLD);
   end

   cd_count #(.NUM_STAGES(NUM_STAGES)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl_i (ctrl),
      .q_o    (div_o)
   );

endmodule

// File: rtl/clkdiv_guarded_chk.sv
`timescale 1ns/1ps
module clkdiv_guarded_chk #(
   parameter int unsigned NUM_STAGES = 4,
   parameter int unsigned GUARD_CYC  = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  clk_in,
   input logic                  div_rst_i,
   input logic                  style_i,
   input logic [NUM_STAGES-1:0] div_o
);
   localparam int unsigned GW = clkdiv_pkg::width_for(GUARD_CYC);
   localparam logic [GW-1:0] FULL = GW'(GUARD_CYC);
   localparam logic [GW-1:0] G1   = GW'(1);
   localparam logic [NUM_STAGES-1:0] ONE = NUM_STAGES'(1);

   logic          tick_d, rst_d;
   logic [GW-1:0] win;
   logic          tr, rr;

   assign tr = clk_in & ~tick_d;
   assign rr = div_rst_i & ~rst_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_d <= 1'b0;
         rst_d  <= 1'b0;
         win    <= FULL;
      end else begin
         tick_d <= clk_in;
         rst_d  <= div_rst_i;
         if (rr || (style_i && div_rst_i)) win <= FULL;
         else if (win != '0)               win <= win - G1;
      end
   end

   p_preset_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!style_i && rr) |=> (div_o == '1));

   p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i && div_rst_i) |=> (div_o == '0));

   p_guard_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win != '0 && !div_rst_i) |=> $stable(div_o));

   p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!style_i && !div_rst_i && tr && win == '0) |=> (div_o == $past(div_o) - ONE));

   p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i && !div_rst_i && tr && win == '0) |=> (div_o == $past(div_o) + ONE));

   p_no_edge_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tr && !rr && !(style_i && div_rst_i)) |=> $stable(div_o));

   p_tie_reset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tr && rr && !style_i) |=> (div_o == '1));

endmodule

bind clkdiv_guarded clkdiv_guarded_chk #(
   .NUM_STAGES (NUM_STAGES),
   .GUARD_CYC  (GUARD_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_in    (clk_in),
   .div_rst_i (div_rst_i),
   .style_i   (style_i),
   .div_o     (div_o)
);

// File: tb/test_clkdiv_guarded.sv
`timescale 1ns/1ps
module test_clkdiv_guarded;
   localparam int G = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       clk_in;
   logic       div_rst_i;
   logic       style_i;
   logic [3:0] div_o;

   int n_run  = 0;
   int n_fail = 0;
   int exp_v  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   clkdiv_guarded i_clkdiv_guarded (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_in    (clk_in),
      .div_rst_i (div_rst_i),
      .style_i   (style_i),
      .div_o     (div_o)
   );

   task automatic check(input string req, input int expv);
      n_run++;
      if (div_o !== 4'(expv)) begin
         n_fail++;
         $display("FAIL %s: div_o=%0d expected %0d at %0t", req, div_o, expv, $time);
      end
   endtask

   task automatic pulse();
      clk_in = 1'b1;
      @(negedge clk);
      clk_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic rst_pulse();
      div_rst_i = 1'b1;
      @(negedge clk);
      div_rst_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; clk_in = 1'b0; div_rst_i = 1'b0; style_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset state", 0);
      pulse();                              // inside power-up guard
      check("R1 power-up guard", 0);
      repeat (G) @(negedge clk);
      pulse();                              // preset style, wraps 0 -> 15
      check("R4 wrap down", 15);

      // Preset reset with guard boundary
      pulse(); check("R4 step", 14);
      rst_pulse();
      check("R2 preset load", 15);
      repeat (G-1) @(negedge clk);
      pulse();                              // seen G cycles after reset edge
      check("R7 edge at window end ignored", 15);
      pulse(); check("R3 first edge /2 low", 14);
      pulse(); check("R3 second edge /4 low", 13);
      exp_v = 13;
      for (int k = 0; k < 17; k++) begin
         pulse();
         exp_v = (exp_v - 1) & 15;
         check("R4 down sweep", exp_v);
      end

      // Exact first accepted edge after the window
      rst_pulse();
      repeat (G) @(negedge clk);
      pulse();
      check("R7 edge just after window accepted", 14);

      // Reset while clock level is high; held-high clock
      clk_in = 1'b1;
      @(negedge clk);
      check("R9 rising edge counts", 13);
      rst_pulse();
      check("R2 load with clock high", 15);
      repeat (G+2) @(negedge clk);
      check("R9 held high no count", 15);
      clk_in = 1'b0;
      @(negedge clk);
      check("R9 falling edge no count", 15);
      pulse(); check("R4 step after high-level reset", 14);

      // Preset reset held high is edge-sensitive
      div_rst_i = 1'b1;
      @(negedge clk);
      check("R10 load on edge", 15);
      repeat (G) @(negedge clk);
      pulse();
      check("R10 counts while reset held", 14);
      div_rst_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset fall no effect", 14);

      // Reset and clock in the same cycle, preset style
      clk_in = 1'b1; div_rst_i = 1'b1;
      @(negedge clk);
      check("R8 preset tie", 15);
      clk_in = 1'b0; div_rst_i = 1'b0;
      repeat (G+2) @(negedge clk);

      // Hold style
      style_i = 1'b1;
      div_rst_i = 1'b1;
      @(negedge clk);
      check("R5 hold clears", 0);
      for (int k = 0; k < 3; k++) begin
         pulse();
         check("R5 edges ignored while held", 0);
      end
      div_rst_i = 1'b0;
      repeat (G-1) @(negedge clk);
      pulse();
      check("R7 hold window end ignored", 0);
      pulse(); check("R6 first up step", 1);
      exp_v = 1;
      for (int k = 0; k < 17; k++) begin
         pulse();
         exp_v = (exp_v + 1) & 15;
         check("R6 up sweep", exp_v);
      end

      // Reset and clock in the same cycle, hold style
      clk_in = 1'b1; div_rst_i = 1'b1;
      @(negedge clk);
      check("R8 hold tie", 0);
      clk_in = 1'b0; div_rst_i = 1'b0;
      repeat (G) @(negedge clk);
      pulse();
      check("R6 step after hold release", 1);

      finish_run();
   end

endmodule